// File: doc/BRIEF.md
# Pipelined Data Memory Responder with Wait States

This block answers the data port of a processor pipeline. A request is offered in one cycle with its address, direction, byte enables and write data all present together, so a store needs no second cycle. An accepted request moves into a single in-progress slot. The response, a wait flag plus read data, belongs to the cycle after acceptance. A programmable number of wait cycles can stretch each access. Storage is a small synchronous word-addressed RAM with byte-lane writes.

The rule for taking a request uses only the registered access and the block's own wait output. The slot loads a new request whenever nothing is in progress or wait is low, and it holds otherwise. A requester that sees wait high keeps its request on the port, and that request is taken in the cycle the current access completes. Wait never refuses a request directly. It only decides whether the access in progress finishes.

A three-state controller does the sequencing. IDLE means no access is in progress. STALL means an access is in progress and wait is high. FINISH means the access completes in this cycle. The transitions are as follows. Load-stall goes from IDLE or FINISH to STALL when a request is taken with a nonzero count. Load-finish goes from IDLE or FINISH to FINISH when a request is taken with a zero count. Drain goes from FINISH to IDLE when no request is offered. Count-down stays in STALL while more than one wait cycle remains. Release goes from STALL to FINISH on the last wait cycle.

Top module: `dmem_responder`

## Requirements
- R1: After the active-low reset `rst_n` is asserted, no access is in progress. `rsp_wait` and `rsp_valid` are low, and they stay low until a request is taken.
- R2: A request is taken exactly when `req_valid` is high and either no access is in progress or `rsp_wait` is low. A request held on the port while `rsp_wait` is high is taken once, in the completing cycle of the current access. No request is lost and none is completed twice, and completions occur in acceptance order.
- R3: With a wait count of 0, `rsp_valid` is high in the cycle right after the request was taken.
- R4: With a wait count of N (taken from `wait_cfg` in the accepting cycle), `rsp_wait` is high for exactly N consecutive cycles after acceptance. `rsp_valid` is high in the cycle after those N cycles. `rsp_wait` and `rsp_valid` are never high together.
- R5: `rsp_wait` depends only on the in-progress access. With no access in progress it is low, whatever is offered on the request port.
- R6: A write changes only the byte lanes whose `req_be` bit is set, where bit i covers data bits 8i+7..8i. A write with all enables clear leaves the word unchanged.
- R7: In a completing read cycle, `rsp_rdata` equals the stored word at the access's word address. In every cycle where `rsp_valid` is low, `rsp_rdata` is zero.
- R8: A write commits at the end of its completing cycle, so a read taken in that same cycle returns the new data.
- R9: A wait count of 0 never raises `rsp_wait`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wait_cfg | input | WAIT_W | Wait cycles applied to a request taken this cycle |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_be | input | DATA_W/8 | Byte-lane enables for writes |
| req_wdata | input | DATA_W | Write data, valid with the request |
| rsp_wait | output | 1 | Access in progress is not completing this cycle |
| rsp_valid | output | 1 | Access in progress completes this cycle |
| rsp_rdata | output | DATA_W | Read data in the completing cycle, else zero |

## Verification
The assertions assume the requester obeys the acceptance rule as seen at the port: a request counts as taken only in a cycle where `rsp_wait` is low, and `wait_cfg` is read only in that cycle. The stimulus drives every request and its wait count together, and it holds both unchanged until the bench's own model of the rule (nothing pending, or wait low) says the request was taken. Requests therefore arrive back to back while wait is high, but nothing is ever withdrawn early. Every address is written in full before it is first read, so reads never return an uninitialised word.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STALL  = 2'd1,
        ST_FINISH = 2'd2
    } slot_state_e;
endpackage

// File: rtl/dmem_waitctl.sv
module dmem_waitctl
    import dmem_pkg::*;
#(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [WAIT_W-1:0] wait_cfg,
    output logic              take,
    output logic              busy,
    output logic              stall,
    output logic              done
);
    localparam logic [WAIT_W-1:0] ONE = WAIT_W'(1);

    slot_state_e       state_q, state_d;
    logic [WAIT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE, ST_FINISH: begin
                if (req_valid) begin
                    cnt_d   = wait_cfg;
                    state_d = (wait_cfg != '0) ? ST_STALL : ST_FINISH;
                end else begin
                    cnt_d   = '0;
                    state_d = ST_IDLE;
                end
            end
            ST_STALL: begin
                cnt_d = cnt_q - ONE;
                if (cnt_q == ONE) state_d = ST_FINISH;
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        take  = 1'b0;
        busy  = 1'b0;
        stall = 1'b0;
        done  = 1'b0;
        unique case (state_q)
            ST_IDLE:   take = 1'b1;
            ST_STALL: begin
                busy  = 1'b1;
                stall = 1'b1;
            end
            ST_FINISH: begin
                take = 1'b1;
                busy = 1'b1;
                done = 1'b1;
            end
            default: take = 1'b1;
        endcase
    end
endmodule

// File: rtl/dmem_slot.sv
module dmem_slot #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              in_write,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [LANES-1:0]  in_be,
    input  logic [DATA_W-1:0] in_wdata,
    output logic              cur_write,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [LANES-1:0]  cur_be,
    output logic [DATA_W-1:0] cur_wdata
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_write <= 1'b0;
            cur_addr  <= '0;
            cur_be    <= '0;
            cur_wdata <= '0;
        end else if (load) begin
            cur_write <= in_write;
            cur_addr  <= in_addr;
            cur_be    <= in_be;
            cur_wdata <= in_wdata;
        end
    end
endmodule

// File: rtl/dmem_bank.sv
module dmem_bank #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic               clk,
    input  logic               we,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [LANES-1:0]   be,
    input  logic [LANES*8-1:0] wdata,
    output logic [LANES*8-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] cells [DEPTH];
        always_ff @(posedge clk) begin
            if (we && be[g]) cells[addr] <= wdata[g*8 +: 8];
        end
        assign rdata[g*8 +: 8] = cells[addr];
    end
endmodule

// File: rtl/dmem_responder.sv
module dmem_responder #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6,
    parameter int WAIT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WAIT_W-1:0]    wait_cfg,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W/8-1:0]  req_be,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 rsp_wait,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rsp_rdata
);
    localparam int LANES = DATA_W / 8;

    logic              take, busy, done;
    logic              cur_write;
    logic [ADDR_W-1:0] cur_addr;
    logic [LANES-1:0]  cur_be;
    logic [DATA_W-1:0] cur_wdata;
    logic [DATA_W-1:0] word;

    dmem_waitctl #(.WAIT_W(WAIT_W)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .wait_cfg (wait_cfg),
        .take     (take),
        .busy     (busy),
        .stall    (rsp_wait),
        .done     (done)
    );

    dmem_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take && req_valid),
        .in_write (req_write),
        .in_addr  (req_addr),
        .in_be    (req_be),
        .in_wdata (req_wdata),
        .cur_write(cur_write),
        .cur_addr (cur_addr),
        .cur_be   (cur_be),
        .cur_wdata(cur_wdata)
    );

    dmem_bank #(.ADDR_W(ADDR_W), .LANES(LANES)) u_bank (
        .clk  (clk),
        .we   (done && cur_write),
        .addr (cur_addr),
        .be   (cur_be),
        .wdata(cur_wdata),
        .rdata(word)
    );

    assign rsp_valid = done;
    assign rsp_rdata = done ? word : '0;
endmodule

// File: rtl/dmem_responder_chk.sv
module dmem_responder_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6,
    parameter int WAIT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WAIT_W-1:0] wait_cfg,
    input logic              req_valid,
    input logic              rsp_wait,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              busy,
    input logic [ADDR_W-1:0] cur_addr
);
    AST_WAIT_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wait |-> busy); // R5
    AST_WAIT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_wait && rsp_valid)); // R4
    AST_ZERO_CFG_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_wait && wait_cfg == '0) |=> (rsp_valid && !rsp_wait)); // R3 R9
    AST_CFG_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_wait && wait_cfg != '0) |=> rsp_wait); // R4
    AST_HOLD_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wait |=> (busy && $stable(cur_addr))); // R2
    AST_IDLE_WHEN_UNFED: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !rsp_wait) |=> !busy); // R2
    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_rdata == '0)); // R7
endmodule

bind dmem_responder dmem_responder_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WAIT_W(WAIT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wait_cfg (wait_cfg),
    .req_valid(req_valid),
    .rsp_wait (rsp_wait),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .busy     (busy),
    .cur_addr (cur_addr)
);

// File: tb/tb_dmem_responder.sv
module tb_dmem_responder;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 6;
    localparam int WAIT_W = 4;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef struct packed {
        logic        wr;
        logic [5:0]  addr;
        logic [3:0]  be;
        logic [31:0] data;
        logic [3:0]  cfg;
        logic [1:0]  gap;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 6'd1,  4'hF, 32'h11223344, 4'd0,  2'd0},  // write, RAW next R8
        '{1'b0, 6'd1,  4'h0, 32'h0,        4'd0,  2'd0},  // back-to-back read R3 R8
        '{1'b1, 6'd2,  4'hF, 32'hA5A5A5A5, 4'd2,  2'd0},
        '{1'b1, 6'd2,  4'h5, 32'hFFFFFFFF, 4'd1,  2'd0},  // lanes 0,2 only R6
        '{1'b0, 6'd2,  4'h0, 32'h0,        4'd3,  2'd0},
        '{1'b1, 6'd3,  4'hF, 32'hDEADBEEF, 4'd0,  2'd1},
        '{1'b1, 6'd3,  4'h0, 32'h00000000, 4'd2,  2'd0},  // no lanes R6
        '{1'b0, 6'd3,  4'h0, 32'h0,        4'd0,  2'd0},
        '{1'b1, 6'd63, 4'hF, 32'h0F0F0F0F, 4'd15, 2'd0},  // max wait R4
        '{1'b0, 6'd63, 4'h0, 32'h0,        4'd15, 2'd0},
        '{1'b1, 6'd63, 4'h8, 32'h77000000, 4'd1,  2'd2},
        '{1'b0, 6'd63, 4'h0, 32'h0,        4'd0,  2'd0},
        '{1'b0, 6'd1,  4'h0, 32'h0,        4'd2,  2'd0},
        '{1'b0, 6'd2,  4'h0, 32'h0,        4'd0,  2'd0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [WAIT_W-1:0] wait_cfg = '0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [3:0]        req_be = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_wait, rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;

    always #2.5 clk = ~clk;

    dmem_responder #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) dut (
        .clk(clk), .rst_n(rst_n), .wait_cfg(wait_cfg), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
        .req_wdata(req_wdata), .rsp_wait(rsp_wait), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata)
    );

    int tests = 0;
    int fails = 0;
    logic [31:0] refm [DEPTH];
    bit          pend = 0;
    logic        p_wr;
    logic [5:0]  p_addr;
    logic [3:0]  p_be;
    logic [31:0] p_data;
    int          p_cfg, p_waits;
    int          issued = 0, completed = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one cycle: drive after negedge, sample just before posedge
    task automatic tick(input bit v, input vec_t x, output bit acc);
        @(negedge clk);
        req_valid = v;
        req_write = x.wr;
        req_addr  = x.addr;
        req_be    = x.be;
        req_wdata = x.data;
        wait_cfg  = x.cfg;
        #2;
        acc = 0;
        if (!pend) check(!rsp_wait, "R5 wait with nothing in progress", rsp_wait, 0);
        if (!rsp_valid) check(rsp_rdata == 0, "R7 rdata idle", rsp_rdata, 0);
        if (pend && rsp_wait) p_waits++;
        if (rsp_valid) begin
            check(pend, "R2 completion without request", 0, 1);
            if (pend) begin
                check(p_waits == p_cfg, (p_cfg == 0) ? "R9 wait cycles" : "R4 wait cycles",
                      p_waits, p_cfg);
                if (!p_wr) check(rsp_rdata == refm[p_addr], "R7 R6 read data",
                                 rsp_rdata, refm[p_addr]);
                else for (int b = 0; b < 4; b++)
                    if (p_be[b]) refm[p_addr][b*8 +: 8] = p_data[b*8 +: 8];
                completed++;
                pend = 0;
            end
        end else if (pend && !rsp_wait) begin
            check(0, "R3 access neither waiting nor done", 0, 1);
            pend = 0;
        end
        if (v && !rsp_wait) begin
            acc = 1; pend = 1; issued++;
            p_wr = x.wr; p_addr = x.addr; p_be = x.be; p_data = x.data;
            p_cfg = x.cfg; p_waits = 0;
        end
    endtask

    task automatic idle(input int n);
        bit a;
        vec_t z;
        z = '0;
        for (int i = 0; i < n; i++) tick(0, z, a);
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", completed, issued);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        bit a;
        vec_t x;
        for (int i = 0; i < DEPTH; i++) refm[i] = '0;
        repeat (3) @(negedge clk);
        #2;
        check(!rsp_wait && !rsp_valid, "R1 reset outputs", {rsp_wait, rsp_valid}, 0);
        @(negedge clk);
        rst_n = 1;
        idle(2);
        // table walk: each request held on the port until taken
        for (int k = 0; k < NV; k++) begin
            do tick(1, VECS[k], a); while (!a);
            idle(VECS[k].gap);
        end
        idle(20);
        check(issued == completed && !pend, "R2 no loss or duplication", completed, issued);
        // R2: request held through a long stall is taken exactly once
        x = '{1'b1, 6'd9, 4'hF, 32'hCAFEF00D, 4'd5, 2'd0};
        do tick(1, x, a); while (!a);
        x = '{1'b0, 6'd9, 4'h0, 32'h0, 4'd0, 2'd0};
        do tick(1, x, a); while (!a);
        idle(3);
        check(issued == completed, "R2 held request count", completed, issued);
        // R1: reset in the middle of a stalled access
        x = '{1'b1, 6'd9, 4'hF, 32'h12345678, 4'd6, 2'd0};
        do tick(1, x, a); while (!a);
        idle(2);
        @(negedge clk);
        req_valid = 0;
        rst_n = 0;
        @(negedge clk);
        #2;
        check(!rsp_wait && !rsp_valid, "R1 reset clears access", {rsp_wait, rsp_valid}, 0);
        pend = 0;
        issued = completed;
        rst_n = 1;
        idle(4);
        check(!rsp_wait && !rsp_valid, "R1 idle after reset", {rsp_wait, rsp_valid}, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule